// File: doc/BRIEF.md
# FM Synthesizer Register Write Decoder

This block sits behind the host register port of a two-bank FM sound generator. Each write supplies a bank flag, an 8-bit register address and a data byte. The block turns that write into a one-cycle update strobe. The strobe carries a dense operator index (0 to 35) or a channel index (0 to 17), together with the parameter value already converted to the form the envelope, phase and routing engines expect. The register slot map is sparse, so the block folds it onto a contiguous operator numbering. It also turns raw 4-bit rate and level nibbles into odd-valued envelope rates and scaled attenuation levels.

Two global settings come in as plain inputs: an extended-mode flag and a six-bit mask of channel pairs that run as four-operator voices. In extended mode, the frequency writes to the upper channel of an enabled pair are dropped. The block keeps a small amount of state of its own. For each operator it keeps the sustain-hold bit and the last release rate, which lets it derive the sustain rate. For each channel it keeps the last key bit, which lets it flag key transitions.

Top module: `fm_reg_decoder`

## Requirements
- R1: No strobe follows a cycle with `wr_en` low. No strobe follows a write to address 0x00, to any address in 0x00-0x1F, or to any address in 0xD0-0xDF.
- R2: Operator groups are addresses below 0xA0 and addresses from 0xE0 upward. In these groups the slot is address bits 4:0. Slots 6, 7, 14, 15 and 22-31 produce no strobe. Slots 16-21 map to slot-4, slots 8-13 map to slot-2 and slots 0-5 map to themselves. Bank 1 adds 18 to the result.
- R3: Channel groups are addresses 0xA0-0xCF. The channel is address bits 3:0, plus 9 when the write targets bank 1. A low nibble from 9 to 15 produces no strobe.
- R4: A write to 0x20-0x3F raises `ctrl_stb`, with `mult` = data[3:0] and `am_en` = data[7]. In the same cycle it raises `sus_rate_stb`. `sus_rate` is 0 when data[5] is 1. Otherwise `sus_rate` is the release rate last stored for that operator, which is 0 after reset.
- R5: A write to 0x40-0x5F raises `level_stb`, with `total_level` = data[5:0] × 64.
- R6: A write to 0x60-0x7F raises `ad_stb`, with `attack_rate` = 2×data[7:4]+1 and `decay_rate` = 2×data[3:0]+1.
- R7: A write to 0x80-0x9F raises `rel_stb`, with `release_rate` = 2×data[3:0]+1. `sus_level` is data[7:4] × 128, except that a nibble of 15 gives all ones (0xFFF).
- R8: A write to 0x80-0x9F also raises `sus_rate_stb`, with `sus_rate` equal to the new release rate, but only when the last 0x20-group write to that operator had data[5] = 0 (or there has been none). Every such write stores the new release rate for later use by R4.
- R9: A write to 0xE0-0xFF raises `wave_stb`. `wave_sel` is data[2:0] when `ext_mode` is 1 and {0, data[1:0]} when it is 0.
- R10: A write to 0xA0-0xAF raises `flo_stb` with `fnum_lo` = data. A write to 0xB0-0xBF raises `fhi_stb` with `fnum_hi` = data[1:0], `block` = data[4:2] and `key_on` = data[5]. `key_edge` is 1 when data[5] differs from the data[5] of the previous 0xB0-group write to the same channel. That previous write counts even if it was dropped under R11.
- R11: Some frequency writes are dropped. A write to 0xA0-0xBF with low nibble 3, 4 or 5 produces no strobe when `ext_mode` is 1 and `four_op_en[n-3 + 3×bank]` is 1.
- R12: A write to 0xC0-0xCF raises `route_stb`, with `alg` = data[0], `feedback` = data[3:1] and `out_en` = data[7:4]. This write is never dropped by R11.
- R13: Every output is registered. A write sampled at one rising edge drives its strobes during the cycle after that edge. Each strobe stays high for one cycle per write. At most one of the strobes other than `sus_rate_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, sampled at the rising edge |
| wr_part | input | 1 | Register bank select (0 or 1) |
| wr_addr | input | 8 | Register address within the bank |
| wr_data | input | 8 | Data byte |
| ext_mode | input | 1 | Extended mode flag |
| four_op_en | input | 6 | Four-operator enable per channel pair |
| op_idx | output | 6 | Dense operator index of the last operator update |
| ch_idx | output | 5 | Channel index of the last channel update |
| ctrl_stb | output | 1 | Multiplier / tremolo update |
| mult | output | 4 | Frequency multiplier |
| am_en | output | 1 | Amplitude modulation enable |
| sus_rate_stb | output | 1 | Sustain rate update |
| sus_rate | output | 5 | Sustain-phase rate |
| level_stb | output | 1 | Total level update |
| total_level | output | 12 | Scaled attenuation |
| ad_stb | output | 1 | Attack/decay update |
| attack_rate | output | 5 | Attack rate |
| decay_rate | output | 5 | Decay rate |
| rel_stb | output | 1 | Release/sustain level update |
| release_rate | output | 5 | Release rate |
| sus_level | output | 12 | Sustain level |
| wave_stb | output | 1 | Waveform update |
| wave_sel | output | 3 | Waveform number |
| flo_stb | output | 1 | Frequency low byte update |
| fnum_lo | output | 8 | Frequency number bits 7:0 |
| fhi_stb | output | 1 | Frequency high / block / key update |
| fnum_hi | output | 2 | Frequency number bits 9:8 |
| block | output | 3 | Octave block |
| key_on | output | 1 | Key state written |
| key_edge | output | 1 | Key state differs from previous write |
| route_stb | output | 1 | Algorithm / feedback / output update |
| alg | output | 1 | Connection algorithm bit |
| feedback | output | 3 | Feedback amount |
| out_en | output | 4 | Output enables |

## Verification
The bench writes to slots on both sides of each hole in the operator map and in both banks. This separates a correct slot fold from an off-by-one or a missing bank offset. The sustain-rate path is tested in both orders: a release write before and after a hold-set control write, and a control write after a hold-clear. This tells stored-state dependence apart from a plain data copy. The sustain nibble of 15 and the nibbles just below it show the forced maximum. Key writes are repeated with the same value and with a changed value, and one goes to a locked upper channel. This separates edge detection from level reporting and shows that dropped writes still update the key history. The same waveform byte is written with `ext_mode` low and with it high, and frequency writes go to locked and unlocked pairs. Each decoded write is also followed by one written back-to-back, which exposes strobes that stretch or merge.

// File: rtl/fmw_pkg.sv
`timescale 1ns/1ps
package fmw_pkg;
  // Decoded update class of one host write
  typedef enum logic [3:0] {
    GRP_NONE,
    GRP_CTRL,
    GRP_LEVEL,
    GRP_ENV_AD,
    GRP_ENV_SR,
    GRP_WAVE,
    GRP_FLO,
    GRP_FHI,
    GRP_ROUTE
  } grp_e;

  localparam int RATE_W   = 5;
  localparam int SLOT_MAX = 21;
endpackage

// File: rtl/fmw_addr_map.sv
`timescale 1ns/1ps
module fmw_addr_map
  import fmw_pkg::*;
#(
  parameter int OPS_PER_PART = 18,
  parameter int CH_PER_PART  = 9,
  parameter int OP_W         = 6,
  parameter int CH_W         = 5
) (
  input  logic            part,
  input  logic [7:0]      addr,
  input  logic            ext_mode,
  input  logic [5:0]      four_op_en,
  output grp_e            grp,
  output logic [OP_W-1:0] op_idx,
  output logic [CH_W-1:0] ch_idx,
  output logic            key_track
);
  logic [4:0] slot;
  logic [4:0] dense;
  logic       hole;
  logic       op_space;
  logic [3:0] nib;
  logic [2:0] pair;
  logic [7:0] fop_pad;
  logic       upper_locked;

  always_comb begin
    slot     = addr[4:0];
    hole     = (slot[4:1] == 4'd3) || (slot[4:1] == 4'd7) || (slot > 5'(SLOT_MAX));
    if (slot >= 5'd16)     dense = slot - 5'd4;
    else if (slot >= 5'd8) dense = slot - 5'd2;
    else                   dense = slot;
    op_idx   = OP_W'(dense) + (part ? OP_W'(OPS_PER_PART) : '0);

    nib      = addr[3:0];
    ch_idx   = CH_W'(nib) + (part ? CH_W'(CH_PER_PART) : '0);
    pair     = ((nib >= 4'd3) ? (nib[2:0] - 3'd3) : nib[2:0]) + (part ? 3'd3 : 3'd0);
    fop_pad  = {2'b00, four_op_en};
    upper_locked = ext_mode && (nib >= 4'd3) && (nib <= 4'd5) && fop_pad[pair];

    op_space  = (addr < 8'hA0) || (addr >= 8'hE0);
    grp       = GRP_NONE;
    key_track = 1'b0;
    if (op_space) begin
      if (!hole) begin
        case (addr[7:5])
          3'b001:  grp = GRP_CTRL;
          3'b010:  grp = GRP_LEVEL;
          3'b011:  grp = GRP_ENV_AD;
          3'b100:  grp = GRP_ENV_SR;
          3'b111:  grp = GRP_WAVE;
          default: grp = GRP_NONE;
        endcase
      end
    end else if (nib <= 4'd8) begin
      case (addr[7:4])
        4'hA: if (!upper_locked) grp = GRP_FLO;
        4'hB: begin
          key_track = 1'b1;
          if (!upper_locked) grp = GRP_FHI;
        end
        4'hC:    grp = GRP_ROUTE;
        default: grp = GRP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fmw_state_mem.sv
`timescale 1ns/1ps
module fmw_state_mem
  import fmw_pkg::*;
#(
  parameter int N_OP = 36,
  parameter int N_CH = 18,
  parameter int OP_W = 6,
  parameter int CH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_idx,
  input  logic [CH_W-1:0]   ch_idx,
  input  logic              we_rel,
  input  logic [RATE_W-1:0] rel_val,
  input  logic              we_hold,
  input  logic              hold_val,
  input  logic              we_key,
  input  logic              key_val,
  output logic [RATE_W-1:0] rd_rel,
  output logic              rd_hold,
  output logic              rd_key
);
  logic [RATE_W-1:0] rel_q  [N_OP];
  logic [N_OP-1:0]   hold_q;
  logic [N_CH-1:0]   key_q;

  for (genvar i = 0; i < N_OP; i++) begin : g_op
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rel_q[i]  <= '0;
        hold_q[i] <= 1'b0;
      end else begin
        if (we_rel && (op_idx == OP_W'(i)))   rel_q[i]  <= rel_val;
        if (we_hold && (op_idx == OP_W'(i)))  hold_q[i] <= hold_val;
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               key_q[c] <= 1'b0;
      else if (we_key && (ch_idx == CH_W'(c)))  key_q[c] <= key_val;
    end
  end

  always_comb begin
    rd_rel  = '0;
    rd_hold = 1'b0;
    rd_key  = 1'b0;
    for (int i = 0; i < N_OP; i++) begin
      if (op_idx == OP_W'(i)) begin
        rd_rel  = rel_q[i];
        rd_hold = hold_q[i];
      end
    end
    for (int c = 0; c < N_CH; c++) begin
      if (ch_idx == CH_W'(c)) rd_key = key_q[c];
    end
  end
endmodule

// File: rtl/fm_reg_decoder.sv
`timescale 1ns/1ps
module fm_reg_decoder
  import fmw_pkg::*;
#(
  parameter int OPS_PER_PART = 18,
  parameter int CH_PER_PART  = 9,
  parameter int ENV_W        = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_part,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  ext_mode,
  input  logic [5:0]            four_op_en,
  output logic [$clog2(2*OPS_PER_PART)-1:0] op_idx,
  output logic [$clog2(2*CH_PER_PART)-1:0]  ch_idx,
  output logic                  ctrl_stb,
  output logic [3:0]            mult,
  output logic                  am_en,
  output logic                  sus_rate_stb,
  output logic [RATE_W-1:0]     sus_rate,
  output logic                  level_stb,
  output logic [ENV_W-1:0]      total_level,
  output logic                  ad_stb,
  output logic [RATE_W-1:0]     attack_rate,
  output logic [RATE_W-1:0]     decay_rate,
  output logic                  rel_stb,
  output logic [RATE_W-1:0]     release_rate,
  output logic [ENV_W-1:0]      sus_level,
  output logic                  wave_stb,
  output logic [2:0]            wave_sel,
  output logic                  flo_stb,
  output logic [7:0]            fnum_lo,
  output logic                  fhi_stb,
  output logic [1:0]            fnum_hi,
  output logic [2:0]            block,
  output logic                  key_on,
  output logic                  key_edge,
  output logic                  route_stb,
  output logic                  alg,
  output logic [2:0]            feedback,
  output logic [3:0]            out_en
);
  localparam int N_OP = 2 * OPS_PER_PART;
  localparam int N_CH = 2 * CH_PER_PART;
  localparam int OP_W = $clog2(N_OP);
  localparam int CH_W = $clog2(N_CH);
  localparam logic [ENV_W-1:0] MAX_ENV = {ENV_W{1'b1}};

  grp_e              grp;
  logic [OP_W-1:0]   dec_op;
  logic [CH_W-1:0]   dec_ch;
  logic              key_track;
  logic [RATE_W-1:0] rd_rel;
  logic              rd_hold;
  logic              rd_key;
  logic [RATE_W-1:0] new_rel;

  fmw_addr_map #(
    .OPS_PER_PART(OPS_PER_PART), .CH_PER_PART(CH_PER_PART), .OP_W(OP_W), .CH_W(CH_W)
  ) u_map (
    .part(wr_part), .addr(wr_addr), .ext_mode(ext_mode), .four_op_en(four_op_en),
    .grp(grp), .op_idx(dec_op), .ch_idx(dec_ch), .key_track(key_track)
  );

  assign new_rel = {wr_data[3:0], 1'b1};

  fmw_state_mem #(.N_OP(N_OP), .N_CH(N_CH), .OP_W(OP_W), .CH_W(CH_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .op_idx(dec_op), .ch_idx(dec_ch),
    .we_rel(wr_en && (grp == GRP_ENV_SR)), .rel_val(new_rel),
    .we_hold(wr_en && (grp == GRP_CTRL)), .hold_val(wr_data[5]),
    .we_key(wr_en && key_track), .key_val(wr_data[5]),
    .rd_rel(rd_rel), .rd_hold(rd_hold), .rd_key(rd_key)
  );

  // Next-state strobes and value enables
  logic op_upd, ch_upd;
  logic ctrl_n, sus_n, level_n, ad_n, rel_n, wave_n, flo_n, fhi_n, route_n;
  logic [RATE_W-1:0] sus_rate_n;
  logic [ENV_W-1:0]  sus_level_n;

  always_comb begin
    ctrl_n  = wr_en && (grp == GRP_CTRL);
    level_n = wr_en && (grp == GRP_LEVEL);
    ad_n    = wr_en && (grp == GRP_ENV_AD);
    rel_n   = wr_en && (grp == GRP_ENV_SR);
    wave_n  = wr_en && (grp == GRP_WAVE);
    flo_n   = wr_en && (grp == GRP_FLO);
    fhi_n   = wr_en && (grp == GRP_FHI);
    route_n = wr_en && (grp == GRP_ROUTE);
    sus_n   = ctrl_n || (rel_n && !rd_hold);
    sus_rate_n = ctrl_n ? (wr_data[5] ? '0 : rd_rel) : new_rel;
    sus_level_n = (wr_data[7:4] == 4'hF) ? MAX_ENV : ENV_W'({wr_data[7:4], 7'b0});
    op_upd  = ctrl_n || level_n || ad_n || rel_n || wave_n;
    ch_upd  = flo_n || fhi_n || route_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_stb <= 1'b0; sus_rate_stb <= 1'b0; level_stb <= 1'b0; ad_stb <= 1'b0;
      rel_stb <= 1'b0; wave_stb <= 1'b0; flo_stb <= 1'b0; fhi_stb <= 1'b0; route_stb <= 1'b0;
      op_idx <= '0; ch_idx <= '0; mult <= '0; am_en <= 1'b0; sus_rate <= '0;
      total_level <= '0; attack_rate <= '0; decay_rate <= '0; release_rate <= '0;
      sus_level <= '0; wave_sel <= '0; fnum_lo <= '0; fnum_hi <= '0; block <= '0;
      key_on <= 1'b0; key_edge <= 1'b0; alg <= 1'b0; feedback <= '0; out_en <= '0;
    end else begin
      ctrl_stb <= ctrl_n; sus_rate_stb <= sus_n; level_stb <= level_n; ad_stb <= ad_n;
      rel_stb <= rel_n; wave_stb <= wave_n; flo_stb <= flo_n; fhi_stb <= fhi_n;
      route_stb <= route_n;
      if (op_upd)  op_idx <= dec_op;
      if (ch_upd)  ch_idx <= dec_ch;
      if (ctrl_n)  begin mult <= wr_data[3:0]; am_en <= wr_data[7]; end
      if (sus_n)   sus_rate <= sus_rate_n;
      if (level_n) total_level <= ENV_W'({wr_data[5:0], 6'b0});
      if (ad_n)    begin attack_rate <= {wr_data[7:4], 1'b1}; decay_rate <= new_rel; end
      if (rel_n)   begin release_rate <= new_rel; sus_level <= sus_level_n; end
      if (wave_n)  wave_sel <= ext_mode ? wr_data[2:0] : {1'b0, wr_data[1:0]};
      if (flo_n)   fnum_lo <= wr_data;
      if (fhi_n) begin
        fnum_hi  <= wr_data[1:0];
        block    <= wr_data[4:2];
        key_on   <= wr_data[5];
        key_edge <= wr_data[5] ^ rd_key;
      end
      if (route_n) begin
        alg <= wr_data[0]; feedback <= wr_data[3:1]; out_en <= wr_data[7:4];
      end
    end
  end
endmodule

// File: rtl/fmw_checker.sv
`timescale 1ns/1ps
module fmw_checker #(
  parameter int OP_W  = 6,
  parameter int CH_W  = 5,
  parameter int N_OP  = 36,
  parameter int N_CH  = 18,
  parameter int ENV_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_part,
  input logic [7:0]      wr_addr,
  input logic            ext_mode,
  input logic [5:0]      four_op_en,
  input logic [OP_W-1:0] op_idx,
  input logic [CH_W-1:0] ch_idx,
  input logic            ctrl_stb,
  input logic            sus_rate_stb,
  input logic            level_stb,
  input logic [ENV_W-1:0] total_level,
  input logic            ad_stb,
  input logic [4:0]      attack_rate,
  input logic [4:0]      decay_rate,
  input logic            rel_stb,
  input logic [ENV_W-1:0] sus_level,
  input logic            wave_stb,
  input logic [2:0]      wave_sel,
  input logic            flo_stb,
  input logic            fhi_stb,
  input logic            route_stb
);
  logic [8:0] main_stbs;
  logic       op_any, ch_any, any_stb;
  logic [7:0] fop_pad;
  logic [2:0] pair;
  logic       locked_wr;

  always_comb begin
    main_stbs = {ctrl_stb, level_stb, ad_stb, rel_stb, wave_stb, flo_stb, fhi_stb, route_stb, 1'b0};
    op_any    = ctrl_stb || sus_rate_stb || level_stb || ad_stb || rel_stb || wave_stb;
    ch_any    = flo_stb || fhi_stb || route_stb;
    any_stb   = op_any || ch_any;
    fop_pad   = {2'b00, four_op_en};
    pair      = wr_addr[2:0] - 3'd3 + (wr_part ? 3'd3 : 3'd0);
    locked_wr = wr_en && ext_mode && (wr_addr[7:5] == 3'b101) &&
                (wr_addr[3:0] >= 4'd3) && (wr_addr[3:0] <= 4'd5) && fop_pad[pair];
  end

  assert_single_update_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(main_stbs));
  assert_strobe_after_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(wr_en));
  assert_null_addr_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h00) |=> !any_stb);
  assert_op_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_any |-> (op_idx < OP_W'(N_OP)));
  assert_ch_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ch_any |-> (ch_idx < CH_W'(N_CH)));
  assert_level_grain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level_stb |-> (total_level[5:0] == 6'd0));
  assert_odd_rates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ad_stb |-> (attack_rate[0] && decay_rate[0]));
  assert_sus_level_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_stb |-> ((&sus_level) || (sus_level[6:0] == 7'd0)));
  assert_wave_narrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ext_mode) |=> (!wave_stb || !wave_sel[2]));
  assert_locked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    locked_wr |=> (!flo_stb && !fhi_stb));
endmodule

bind fm_reg_decoder fmw_checker #(
  .OP_W(OP_W), .CH_W(CH_W), .N_OP(N_OP), .N_CH(N_CH), .ENV_W(ENV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_part(wr_part), .wr_addr(wr_addr),
  .ext_mode(ext_mode), .four_op_en(four_op_en), .op_idx(op_idx), .ch_idx(ch_idx),
  .ctrl_stb(ctrl_stb), .sus_rate_stb(sus_rate_stb), .level_stb(level_stb),
  .total_level(total_level), .ad_stb(ad_stb), .attack_rate(attack_rate),
  .decay_rate(decay_rate), .rel_stb(rel_stb), .sus_level(sus_level),
  .wave_stb(wave_stb), .wave_sel(wave_sel), .flo_stb(flo_stb), .fhi_stb(fhi_stb),
  .route_stb(route_stb)
);

// File: tb/fm_reg_decoder_tb.sv
`timescale 1ns/1ps
module fm_reg_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, wr_en, wr_part, ext_mode;
  logic [7:0] wr_addr, wr_data;
  logic [5:0] four_op_en;
  logic [5:0] op_idx;
  logic [4:0] ch_idx;
  logic ctrl_stb, am_en, sus_rate_stb, level_stb, ad_stb, rel_stb, wave_stb;
  logic flo_stb, fhi_stb, key_on, key_edge, route_stb, alg;
  logic [3:0] mult, out_en;
  logic [4:0] sus_rate, attack_rate, decay_rate, release_rate;
  logic [11:0] total_level, sus_level;
  logic [2:0] wave_sel, block, feedback;
  logic [7:0] fnum_lo;
  logic [1:0] fnum_hi;

  fm_reg_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_part(wr_part), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_mode(ext_mode), .four_op_en(four_op_en),
    .op_idx(op_idx), .ch_idx(ch_idx), .ctrl_stb(ctrl_stb), .mult(mult), .am_en(am_en),
    .sus_rate_stb(sus_rate_stb), .sus_rate(sus_rate), .level_stb(level_stb),
    .total_level(total_level), .ad_stb(ad_stb), .attack_rate(attack_rate),
    .decay_rate(decay_rate), .rel_stb(rel_stb), .release_rate(release_rate),
    .sus_level(sus_level), .wave_stb(wave_stb), .wave_sel(wave_sel),
    .flo_stb(flo_stb), .fnum_lo(fnum_lo), .fhi_stb(fhi_stb), .fnum_hi(fnum_hi),
    .block(block), .key_on(key_on), .key_edge(key_edge), .route_stb(route_stb),
    .alg(alg), .feedback(feedback), .out_en(out_en)
  );

  typedef struct packed {
    logic [8:0] stb;  // ctrl,sus,level,ad,rel,wave,flo,fhi,route
    logic [5:0] op;
    logic [4:0] ch;
    logic [3:0] mult;
    logic       am;
    logic [4:0] sus;
    logic [11:0] tl;
    logic [4:0] ar, dr, rr;
    logic [11:0] sl;
    logic [2:0] wv;
    logic [7:0] flo;
    logic [1:0] fhi;
    logic [2:0] blk;
    logic       key, kedge, alg;
    logic [2:0] fb;
    logic [3:0] oe;
  } rec_t;

  rec_t  exp_q[$];
  string tag_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Independent model state
  logic [4:0] rel_m [36];
  logic       hold_m[36];
  logic       key_m [18];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic rec_t model(input logic p, input logic [7:0] a, input logic [7:0] d);
    rec_t r = '0;
    logic [4:0] s;
    logic [3:0] n;
    logic [5:0] o;
    logic [4:0] c;
    int pb;
    logic up;
    if (a < 8'hA0 || a >= 8'hE0) begin
      s = a[4:0];
      if (!(s == 6 || s == 7 || s == 14 || s == 15 || s > 21) && a[7:5] != 3'b000) begin
        o = (s >= 16) ? 6'(s - 4) : (s >= 8) ? 6'(s - 2) : 6'(s);
        o = o + (p ? 6'd18 : 6'd0);
        case (a[7:5])
          3'b001: begin
            r.stb[8] = 1; r.stb[7] = 1; r.op = o; r.mult = d[3:0]; r.am = d[7];
            r.sus = d[5] ? 5'd0 : rel_m[o]; hold_m[o] = d[5];
          end
          3'b010: begin r.stb[6] = 1; r.op = o; r.tl = {d[5:0], 6'd0}; end
          3'b011: begin r.stb[5] = 1; r.op = o; r.ar = {d[7:4], 1'b1}; r.dr = {d[3:0], 1'b1}; end
          3'b100: begin
            r.stb[4] = 1; r.op = o; r.rr = {d[3:0], 1'b1};
            r.sl = (d[7:4] == 4'hF) ? 12'hFFF : {1'b0, d[7:4], 7'd0};
            if (!hold_m[o]) begin r.stb[7] = 1; r.sus = r.rr; end
            rel_m[o] = r.rr;
          end
          3'b111: begin r.stb[3] = 1; r.op = o; r.wv = ext_mode ? d[2:0] : {1'b0, d[1:0]}; end
          default: ;
        endcase
      end
    end else begin
      n = a[3:0];
      if (n <= 8) begin
        c  = 5'(n) + (p ? 5'd9 : 5'd0);
        pb = ((n >= 3) ? int'(n) - 3 : int'(n)) + (p ? 3 : 0);
        up = ext_mode && n >= 3 && n <= 5 && four_op_en[pb];
        case (a[7:4])
          4'hA: if (!up) begin r.stb[2] = 1; r.ch = c; r.flo = d; end
          4'hB: begin
            if (!up) begin
              r.stb[1] = 1; r.ch = c; r.fhi = d[1:0]; r.blk = d[4:2];
              r.key = d[5]; r.kedge = d[5] ^ key_m[c];
            end
            key_m[c] = d[5];
          end
          4'hC: begin r.stb[0] = 1; r.ch = c; r.alg = d[0]; r.fb = d[3:1]; r.oe = d[7:4]; end
          default: ;
        endcase
      end
    end
    return r;
  endfunction

  function automatic rec_t snap();
    rec_t a = '0;
    a.stb = {ctrl_stb, sus_rate_stb, level_stb, ad_stb, rel_stb, wave_stb, flo_stb, fhi_stb, route_stb};
    if (|a.stb[8:3]) a.op = op_idx;
    if (|a.stb[2:0]) a.ch = ch_idx;
    if (ctrl_stb) begin a.mult = mult; a.am = am_en; end
    if (sus_rate_stb) a.sus = sus_rate;
    if (level_stb) a.tl = total_level;
    if (ad_stb) begin a.ar = attack_rate; a.dr = decay_rate; end
    if (rel_stb) begin a.rr = release_rate; a.sl = sus_level; end
    if (wave_stb) a.wv = wave_sel;
    if (flo_stb) a.flo = fnum_lo;
    if (fhi_stb) begin a.fhi = fnum_hi; a.blk = block; a.key = key_on; a.kedge = key_edge; end
    if (route_stb) begin a.alg = alg; a.fb = feedback; a.oe = out_en; end
    return a;
  endfunction

  // Driver: one write per call, expected item pushed for the following edge
  task automatic wr(input logic p, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_part = p; wr_addr = a; wr_data = d; wr_en = 1'b1;
    exp_q.push_back(model(p, a, d));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic set_glob(input logic e, input logic [5:0] f);
    @(negedge clk);
    wr_en = 1'b0; ext_mode = e; four_op_en = f;
  endtask

  // Monitor: compares each registered result just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && !done) begin
        rec_t act, e;
        string t;
        act = snap();
        checks++;
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (act !== e) begin
            errors++;
            $display("FAIL %s actual %h expected %h", t, act, e);
          end
        end else if (act.stb != 9'd0) begin
          errors++;
          $display("FAIL R13 idle strobes actual %b expected %b", act.stb, 9'd0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 36; i++) begin rel_m[i] = '0; hold_m[i] = 1'b0; end
    for (int i = 0; i < 18; i++) key_m[i] = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_part = 1'b0; wr_addr = '0; wr_data = '0;
    ext_mode = 1'b0; four_op_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state of held values and strobes (R13)
    checks++;
    if ({ctrl_stb, sus_rate_stb, level_stb, ad_stb, rel_stb, wave_stb, flo_stb, fhi_stb, route_stb} != 0
        || op_idx != 0 || ch_idx != 0 || sus_rate != 0 || total_level != 0 || sus_level != 0) begin
      errors++;
      $display("FAIL R13 reset state actual op=%0d sr=%0d expected zeros", op_idx, sus_rate);
    end

    // R1: null and out-of-scope addresses
    wr(0, 8'h00, 8'hFF, "R1");
    wr(0, 8'h10, 8'h3C, "R1");
    wr(1, 8'hD3, 8'h55, "R1");
    idle(2);

    // R7/R8: release before any control write, then hold interplay (R4)
    wr(0, 8'h80, 8'h35, "R7 R8");
    wr(0, 8'h20, 8'h21, "R4");
    wr(0, 8'h80, 8'hF2, "R7 R8");
    wr(0, 8'h20, 8'h8C, "R4");
    wr(0, 8'h81, 8'hE0, "R7");
    idle(1);

    // R2/R5: operator folding around holes, both banks
    wr(1, 8'h55, 8'h3F, "R2 R5");
    wr(0, 8'h4A, 8'h01, "R2 R5");
    wr(0, 8'h46, 8'h12, "R2");
    wr(0, 8'h4F, 8'h12, "R2");
    wr(0, 8'h56, 8'h12, "R2");
    wr(1, 8'h48, 8'h2A, "R2");
    wr(0, 8'h45, 8'h07, "R2");
    idle(1);

    // R6: attack/decay
    wr(0, 8'h63, 8'hA5, "R6");
    wr(1, 8'h70, 8'hF0, "R6");

    // R9: waveform width per mode
    wr(0, 8'hE1, 8'h07, "R9");
    set_glob(1'b1, 6'b000000);
    wr(0, 8'hE1, 8'h07, "R9");
    set_glob(1'b0, 6'b000000);

    // R10/R3: frequency and key tracking
    wr(0, 8'hA4, 8'h5A, "R10");
    wr(1, 8'hB8, 8'h2D, "R10");
    wr(1, 8'hB8, 8'h2D, "R10");
    wr(1, 8'hB8, 8'h0D, "R10");
    wr(0, 8'hA9, 8'h11, "R3");
    wr(0, 8'hBD, 8'hFF, "R3");
    wr(0, 8'hCF, 8'hFF, "R3");
    idle(1);

    // R11/R12: locked upper channel in four-operator mode
    set_glob(1'b1, 6'b001000);
    wr(1, 8'hA3, 8'h77, "R11");
    wr(1, 8'hB3, 8'h20, "R11");
    wr(0, 8'hA3, 8'h66, "R11");
    wr(1, 8'hC3, 8'hF7, "R12");
    wr(1, 8'hA0, 8'h44, "R11");
    set_glob(1'b0, 6'b001000);
    wr(1, 8'hB3, 8'h20, "R10 R11");
    wr(0, 8'hC8, 8'h5A, "R12");
    idle(3);

    done = 1;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R13 pending results actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule